// File: doc/BRIEF.md
# Programmable Pseudorandom and Repeating-Word Test Pattern Generator

This block produces one serial test bit per qualified time slot of a framed E1/T1-style stream. A single 32-bit shift register serves two purposes. In pseudorandom mode it behaves as a two-tap linear feedback register for a polynomial x^n + x^y + 1. In repetitive mode it rotates the low n bits of a loaded seed. The register shifts from bit 0 toward bit 31, and the feedback always enters bit 0. The output bit is register bit n-1, taken before the shift.

Software presents the length field (n-1), the tap field (y-1), the mode bit, a QRSS option and a seed split into an upper and a lower 16-bit half. None of these values reaches the generator until the load input rises. An external slot qualifier drives `bit_en` high only for the channel bits that carry the pattern. The generator advances one bit for each cycle in which `bit_en` is high and holds its state in every other cycle. In QRSS mode the output is forced to one after 14 consecutive zero outputs. The forced one does not change the register contents.

Top module: `pattern_gen_top`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, `pat_valid` and `pat_out` are 0.
- R2: On a clock edge where `load` is high and was low on the previous edge, the register takes `{seed_hi, seed_lo}`, the configuration inputs are captured, and the QRSS zero-run count is cleared. The output sequence then restarts from that seed.
- R3: Changes to the configuration and seed inputs have no effect unless `load` rises. This includes changes made while `load` is held high after its rising edge.
- R4: While `bit_en` is low and no load edge occurs, `pat_valid` reads 0 on the following cycle and the register holds its state. When `bit_en` returns high, the sequence continues with the next bit.
- R5: For each edge with `bit_en` high and no load edge, `pat_valid` is 1 after that edge and `pat_out` carries register bit `len` as it was before the shift.
- R6: With `rep_mode` = 0 (pseudorandom), the feedback shifted into bit 0 is register bit `len` XOR register bit `tap`. The field values are n-1 and y-1 for x^n + x^y + 1, for example len 0x08 and tap 0x04 for the 2^9-1 pattern.
- R7: With `rep_mode` = 1 (repetitive), the feedback is register bit `len`. The output is therefore seed[len], seed[len-1], …, seed[0], repeating with period len+1.
- R8: With `qrss` = 1, an output bit is forced to 1 when the 14 output bits before it were all 0. A forced one restarts the zero count. The QRSS setting uses len 0x13 and tap 0x02.
- R9: If a load edge and `bit_en` coincide, the load wins: no bit is output (`pat_valid` is 0 after that edge) and the next enabled bit is the first bit of the new seed.
- R10: The 2^9-1 setting (len 0x08, tap 0x04) with a nonzero seed repeats with period 511 and has 256 ones per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 5 | Length field, n-1 |
| cfg_tap | input | 5 | Tap field, y-1 (pseudorandom mode only) |
| cfg_rep_mode | input | 1 | 1 = repeating word, 0 = pseudorandom |
| cfg_qrss | input | 1 | 1 = limit zero runs to 14 bits |
| seed_hi | input | 16 | Upper half of the seed |
| seed_lo | input | 16 | Lower half of the seed |
| load | input | 1 | Rising edge loads the seed and configuration |
| bit_en | input | 1 | Advance one bit in this cycle |
| pat_out | output | 1 | Pattern bit |
| pat_valid | output | 1 | `pat_out` holds a new bit from the previous cycle |

## Verification
The hardest case to reach is the QRSS forcing rule. A live 2^20-1 sequence almost never produces fifteen zeros in a row within a short run, so the rule would seldom be exercised. The stimulus therefore loads the QRSS polynomial with an all-zero seed. This locks the register at zero and makes the output exactly fourteen zeros followed by a one, repeated. A second QRSS run from an all-ones seed is compared bit by bit against a model of the recurrence, and its longest zero run is measured. A further corner case is a load edge in the same cycle as an enable, and another is a held-high load whose inputs change afterwards. Both are driven directly, and the bits that follow show which seed the generator used.

// File: rtl/pg_pkg.sv
// Package: shared sizing and the captured configuration record of the
// pattern generator. Assumes a register width that is a power of two.
package pg_pkg;
    localparam int PG_REG_W      = 32;
    localparam int PG_FIELD_W    = $clog2(PG_REG_W);
    localparam int PG_ZERO_LIMIT = 14;

    typedef struct packed {
        logic [PG_FIELD_W-1:0] len;
        logic [PG_FIELD_W-1:0] tap;
        logic                  rep_mode;
        logic                  qrss;
    } pg_cfg_t;
endpackage

// File: rtl/pg_load_ctrl.sv
// pg_load_ctrl: detects the rising edge of the load input and captures the
// configuration on that edge. Assumes load is synchronous to clk.
module pg_load_ctrl
    import pg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  pg_cfg_t cfg_in,
    output logic    load_edge,
    output pg_cfg_t cfg_q
);
    logic load_q;

    // Rising edge of load relative to its value at the previous clock.
    always_comb load_edge = load & ~load_q;

    // Track load and capture the configuration only on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            load_q <= load;
            if (load_edge) cfg_q <= cfg_in;
        end
    end

    AST_CFG_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_edge |=> $stable(cfg_q)); // R3

    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> (cfg_q == $past(cfg_in))); // R2
endmodule

// File: rtl/pg_shift_core.sv
// pg_shift_core: the shared shift register. It shifts toward the MSB, and
// the feedback enters bit 0. The raw output is bit len before the shift.
// Assumes cfg is stable except in the cycle after a load edge.
module pg_shift_core
    import pg_pkg::*;
#(
    parameter int REG_W = PG_REG_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_edge,
    input  logic             bit_en,
    input  logic [REG_W-1:0] seed,
    input  pg_cfg_t          cfg,
    output logic             raw_bit
);
    logic [REG_W-1:0] sr_q;
    logic             tap_bit;
    logic             fb;

    // Select the output and tap bits, then form the feedback for the mode.
    always_comb begin
        raw_bit = sr_q[cfg.len];
        tap_bit = sr_q[cfg.tap];
        fb      = cfg.rep_mode ? raw_bit : (raw_bit ^ tap_bit);
    end

    // A load edge takes priority, otherwise shift when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         sr_q <= '0;
        else if (load_edge) sr_q <= seed;
        else if (bit_en)    sr_q <= {sr_q[REG_W-2:0], fb};
    end

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> (sr_q == $past(seed))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !load_edge) |=> $stable(sr_q)); // R4

    AST_REP_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !load_edge && cfg.rep_mode) |=> (sr_q[0] == $past(sr_q[cfg.len]))); // R7

    AST_PRBS_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !load_edge && !cfg.rep_mode)
        |=> (sr_q[0] == ($past(sr_q[cfg.len]) ^ $past(sr_q[cfg.tap])))); // R6
endmodule

// File: rtl/pg_zero_limiter.sv
// pg_zero_limiter: registers the output bit and its valid flag. In QRSS
// mode it forces a one after ZERO_LIMIT zero outputs in a row. The shift
// register is not affected by the forcing.
module pg_zero_limiter #(
    parameter int ZERO_LIMIT = pg_pkg::PG_ZERO_LIMIT
)(
    input  logic clk,
    input  logic rst_n,
    input  logic load_edge,
    input  logic bit_en,
    input  logic qrss,
    input  logic raw_bit,
    output logic pat_out,
    output logic pat_valid
);
    localparam int ZCNT_W = $clog2(ZERO_LIMIT + 1);

    logic [ZCNT_W-1:0] zrun_q;
    logic              force_one;
    logic              out_bit;

    // Force a one once the run of zero outputs reaches the limit.
    always_comb begin
        force_one = qrss && (zrun_q == ZCNT_W'(ZERO_LIMIT));
        out_bit   = raw_bit | force_one;
    end

    // Register the output and count zero outputs; a load clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun_q    <= '0;
            pat_out   <= 1'b0;
            pat_valid <= 1'b0;
        end else if (load_edge) begin
            zrun_q    <= '0;
            pat_valid <= 1'b0;
        end else if (bit_en) begin
            pat_out   <= out_bit;
            pat_valid <= 1'b1;
            if (out_bit)                              zrun_q <= '0;
            else if (zrun_q != ZCNT_W'(ZERO_LIMIT))   zrun_q <= zrun_q + ZCNT_W'(1);
        end else begin
            pat_valid <= 1'b0;
        end
    end

    AST_QRSS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !load_edge && qrss && (zrun_q == ZCNT_W'(ZERO_LIMIT))) |=> pat_out); // R8

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !load_edge) |=> pat_valid); // R5

    AST_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> !pat_valid); // R9

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !load_edge) |=> (!pat_valid && $stable(pat_out))); // R4
endmodule

// File: rtl/pattern_gen_top.sv
// pattern_gen_top: a programmable pseudorandom / repeating-word serial test
// pattern generator. The seed is assembled from two halves, and settings
// take effect on a rising edge of load. Assumes the slot qualification is
// done outside and arrives on bit_en.
module pattern_gen_top
    import pg_pkg::*;
#(
    parameter int REG_W  = PG_REG_W,
    parameter int HALF_W = REG_W / 2
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PG_FIELD_W-1:0] cfg_len,
    input  logic [PG_FIELD_W-1:0] cfg_tap,
    input  logic                  cfg_rep_mode,
    input  logic                  cfg_qrss,
    input  logic [HALF_W-1:0]     seed_hi,
    input  logic [HALF_W-1:0]     seed_lo,
    input  logic                  load,
    input  logic                  bit_en,
    output logic                  pat_out,
    output logic                  pat_valid
);
    logic [REG_W-1:0] seed_w;
    pg_cfg_t          cfg_in;
    pg_cfg_t          cfg_q;
    logic             load_edge;
    logic             raw_bit;

    // Join the two seed halves bit by bit.
    for (genvar g = 0; g < HALF_W; g++) begin : g_seed
        assign seed_w[g]          = seed_lo[g];
        assign seed_w[g + HALF_W] = seed_hi[g];
    end

    // Gather the configuration inputs into one record.
    always_comb begin
        cfg_in.len      = cfg_len;
        cfg_in.tap      = cfg_tap;
        cfg_in.rep_mode = cfg_rep_mode;
        cfg_in.qrss     = cfg_qrss;
    end

    pg_load_ctrl u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cfg_in    (cfg_in),
        .load_edge (load_edge),
        .cfg_q     (cfg_q)
    );

    pg_shift_core #(.REG_W(REG_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_edge (load_edge),
        .bit_en    (bit_en),
        .seed      (seed_w),
        .cfg       (cfg_q),
        .raw_bit   (raw_bit)
    );

    pg_zero_limiter #(.ZERO_LIMIT(PG_ZERO_LIMIT)) u_limit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_edge (load_edge),
        .bit_en    (bit_en),
        .qrss      (cfg_q.qrss),
        .raw_bit   (raw_bit),
        .pat_out   (pat_out),
        .pat_valid (pat_valid)
    );
endmodule

// File: tb/tb_pattern_gen_top.sv
module tb_pattern_gen_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_len = '0, cfg_tap = '0;
    logic        cfg_rep_mode = 1'b0, cfg_qrss = 1'b0;
    logic [15:0] seed_hi = '0, seed_lo = '0;
    logic        load = 1'b0, bit_en = 1'b0;
    logic        pat_out, pat_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state: xs[k+32] holds stream bit x[k]; x[-1-i] = seed[i].
    bit xs [0:2047];
    int t, zr;
    int mlen, mtap;
    bit mrep, mqrss;
    bit obs [0:1100];
    int nobs;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_gen_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
        .cfg_rep_mode(cfg_rep_mode), .cfg_qrss(cfg_qrss),
        .seed_hi(seed_hi), .seed_lo(seed_lo), .load(load), .bit_en(bit_en),
        .pat_out(pat_out), .pat_valid(pat_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_init(input logic [31:0] s, input int l, input int tp,
                              input bit r, input bit q);
        for (int i = 0; i < 32; i++) xs[31-i] = s[i];
        t = 0; zr = 0; mlen = l; mtap = tp; mrep = r; mqrss = q;
    endtask

    // Next expected output from the recurrence in the requirements.
    task automatic model_next(output bit o);
        int n, y;
        bit raw;
        n = mlen + 1; y = mtap + 1;
        raw = xs[t+32-n];
        xs[t+32] = mrep ? raw : (raw ^ xs[t+32-y]);
        o = raw | (mqrss && zr == 14);
        if (o) zr = 0; else if (zr < 14) zr++;
        t++;
    endtask

    task automatic set_inputs(input int l, input int tp, input bit r, input bit q,
                              input logic [31:0] s);
        cfg_len = 5'(l); cfg_tap = 5'(tp); cfg_rep_mode = r; cfg_qrss = q;
        seed_hi = s[31:16]; seed_lo = s[15:0];
    endtask

    task automatic do_load(input int l, input int tp, input bit r, input bit q,
                           input logic [31:0] s);
        @(negedge clk);
        set_inputs(l, tp, r, q, s);
        bit_en = 1'b0; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(pat_valid == 1'b0, "R2 valid low after load", pat_valid, 0);
        model_init(s, l, tp, r, q);
    endtask

    // Drive bit_en from the current negedge and check each produced bit.
    task automatic run_bits(input int count, input string req);
        bit e;
        bit_en = 1'b1;
        nobs = 0;
        for (int k = 0; k < count; k++) begin
            @(negedge clk);
            model_next(e);
            check(pat_valid == 1'b1, req, pat_valid, 1);
            check(pat_out == e, req, pat_out, e);
            if (nobs <= 1100) obs[nobs] = pat_out;
            nobs++;
        end
        bit_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pat_valid == 1'b0, "R1 valid in reset", pat_valid, 0);
        check(pat_out == 1'b0, "R1 out in reset", pat_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pat_valid == 1'b0, "R1 valid after reset", pat_valid, 0);
        check(pat_out == 1'b0, "R1 out after reset", pat_out, 0);

        // R7 sweep: every short length with a varied seed, plus standard words.
        for (int l = 0; l < 8; l++) begin
            do_load(l, 0, 1'b1, 1'b0, 32'hA5C3_96E1 ^ (32'h0000_0137 * l));
            run_bits(2*(l+1) + 3, "R7 repeat sweep");
        end
        do_load(0, 0, 1'b1, 1'b0, 32'hFFFF_FFFF);  run_bits(8,  "R7 all ones");
        do_load(0, 0, 1'b1, 1'b0, 32'hFFFF_FFFE);  run_bits(8,  "R7 all zeros");
        do_load(15, 0, 1'b1, 1'b0, 32'hFFFF_0001); run_bits(34, "R7 one in sixteen");
        check(obs[15] == 1 && obs[14] == 0, "R7 one in sixteen position", obs[15], 1);
        do_load(7, 0, 1'b1, 1'b0, 32'hFFFF_FF01);  run_bits(20, "R7 one in eight");
        do_load(23, 0, 1'b1, 1'b0, 32'hFF20_0022); run_bits(52, "R7 three in 24");
        do_load(31, 0, 1'b1, 1'b0, 32'h8001_7E5B); run_bits(70, "R7 full length");

        // R6: each pseudorandom setting.
        do_load(8'h08, 8'h04, 1'b0, 1'b0, 32'hFFFF_FFFF); run_bits(200, "R6 prbs9");
        do_load(8'h0A, 8'h08, 1'b0, 1'b0, 32'hFFFF_FFFF); run_bits(200, "R6 prbs11");
        do_load(8'h0E, 8'h0D, 1'b0, 1'b0, 32'hFFFF_FFFF); run_bits(200, "R6 prbs15");
        do_load(8'h13, 8'h10, 1'b0, 1'b0, 32'hFFFF_FFFF); run_bits(200, "R6 prbs20");
        do_load(8'h16, 8'h11, 1'b0, 1'b0, 32'hFFFF_FFFF); run_bits(200, "R6 prbs23");
        do_load(8'h16, 8'h11, 1'b0, 1'b0, 32'h1357_9BDF); run_bits(100, "R6 prbs23 seed");

        // R10: period and weight of the 2^9-1 pattern.
        do_load(8'h08, 8'h04, 1'b0, 1'b0, 32'hFFFF_FFFF);
        run_bits(1022, "R5 prbs9 long");
        begin
            int ones = 0, mism = 0;
            for (int i = 0; i < 511; i++) begin
                ones += obs[i];
                if (obs[i] != obs[i+511]) mism++;
            end
            check(ones == 256, "R10 ones per period", ones, 256);
            check(mism == 0, "R10 period 511", mism, 0);
        end

        // R8: all-zero seed gives 14 zeros and a forced one, repeated.
        do_load(8'h13, 8'h02, 1'b0, 1'b1, 32'h0000_0000);
        run_bits(45, "R8 qrss zero seed");
        check(obs[14] == 1 && obs[29] == 1 && obs[44] == 1, "R8 forced ones", obs[14], 1);
        check(obs[13] == 0 && obs[0] == 0, "R8 zeros before force", obs[13], 0);
        do_load(8'h13, 8'h02, 1'b0, 1'b1, 32'hFFFF_FFFF);
        run_bits(600, "R8 qrss live");
        begin
            int run = 0, mx = 0;
            for (int i = 0; i < 600; i++) begin
                if (obs[i]) run = 0; else run++;
                if (run > mx) mx = run;
            end
            check(mx <= 14, "R8 max zero run", mx, 14);
        end

        // R4: gaps in the enable hold the sequence.
        do_load(8'h0E, 8'h0D, 1'b0, 1'b0, 32'h0F0F_3C3C);
        for (int g = 0; g < 4; g++) begin
            run_bits(7 + g, "R4 resume after gap");
            for (int i = 0; i < g + 1; i++) begin
                @(negedge clk);
                check(pat_valid == 1'b0, "R4 valid low when idle", pat_valid, 0);
            end
        end

        // R3: inputs change without a load edge.
        do_load(8'h0A, 8'h08, 1'b0, 1'b0, 32'hDEAD_BEEF);
        run_bits(20, "R3 before change");
        @(negedge clk);
        set_inputs(3, 1, 1'b1, 1'b1, 32'h0000_0000);
        run_bits(30, "R3 change ignored");

        // R3: load held high after its edge; later changes are ignored.
        @(negedge clk);
        set_inputs(7, 0, 1'b1, 1'b0, 32'hFFFF_FF01);
        load = 1'b1;
        @(negedge clk);
        model_init(32'hFFFF_FF01, 7, 0, 1'b1, 1'b0);
        set_inputs(3, 0, 1'b1, 1'b0, 32'h0000_1234);
        run_bits(24, "R3 held load");
        load = 1'b0;
        run_bits(8, "R3 after held load");

        // R9: load edge in the same cycle as an enable.
        do_load(8'h0A, 8'h08, 1'b0, 1'b0, 32'hFFFF_FFFF);
        run_bits(5, "R9 before collision");
        @(negedge clk);
        set_inputs(15, 0, 1'b1, 1'b0, 32'hFFFF_0001);
        load = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        check(pat_valid == 1'b0, "R9 no bit on load", pat_valid, 0);
        load = 1'b0;
        model_init(32'hFFFF_0001, 15, 0, 1'b1, 1'b0);
        run_bits(20, "R9 new seed first");
        check(obs[15] == 1 && obs[0] == 0, "R9 new seed position", obs[15], 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule